// File: doc/BRIEF.md
# Grid-Interactive Mode Transfer Supervisor

This block decides, on every clock, whether a single-phase inverter runs tied to the grid as a harmonic and power-factor filter or islanded as a backup source. It drives the gate of a fast static bypass switch and tells the inverter's controllers which mode to run. It also says whether the output reference should lock to the grid or free-run, whether the output amplitude should be full or reduced, and when the grid-current reference may start its ramp. The PLL, the current and voltage loops and the PWM sit outside this block. They consume these selects.

A grid sample is judged bad when the grid flag drops, or when the RMS error magnitude exceeds a fixed fraction (about 15%) of the nominal RMS reference. That fraction is formed by a multiply and a shift, so no divider is needed. One bad sample is enough to open the switch. Islanded operation begins only after the switch reports open. Reconnection happens only after the output has tracked the grid for a counted run of grid cycles and the switch reports closed.

When the DC link sags while islanded, the block selects a reduced output class. When the link falls further, the block stops the output. If the switch does not confirm a command within a timeout, the block latches a fault and keeps the inverter off until reset.

Top module: `mode_xfer_sup`

## Requirements
- R1: A grid sample is bad when `grid_present` is 0 or when `grid_rms_err > (grid_rms_ref * 154) >> 10`, with all values unsigned. An error equal to that limit is normal.
- R2: In filter mode, one bad sample drops `bypass_gate` to 0 at the next clock edge. At the same edge, `inv_enable` and `iref_ramp_en` drop to 0. There is no wait for a zero crossing.
- R3: After the switch is commanded open, `mode_backup` and `inv_enable` rise only at the edge after a sample with `bypass_fb` = 0 (0 means the switch is open). Until then, both stay 0.
- R4: While islanded, `ref_freerun` is 1 when `grid_present` is 0 and 0 when it is 1. Outside islanded operation, `ref_freerun` is 0.
- R5: While islanded with a good grid, `bypass_gate` returns to 1 only after 5 `cycle_tick` pulses in a row, each sampled with `sync_match` = 1. After the fifth pulse, the gate rises at the next edge but one.
- R6: After reclosing, filter mode starts only at the edge after `bypass_fb` = 1. Filter mode means `mode_backup` = 0, `inv_enable` = 1 and `iref_ramp_en` = 1.
- R7: While islanded, `amp_reduced` is 1 when `dc_link < 320` and 0 otherwise. A `dc_link` sample below 160 stops the output at the next edge, giving `inv_enable` = 0 and `bypass_gate` = 0. From that stopped state, a good grid sample returns the block to the idle state.
- R8: The match count clears when a tick is sampled with `sync_match` = 0. It also clears on any bad grid sample during the wait. After either event, a further 5 matching ticks are needed.
- R9: If `bypass_fb` does not confirm the commanded state within `FB_TMO` cycles, `fb_fault` rises and stays 1 until reset. While it is 1, `inv_enable` = 0 and `bypass_gate` = 0.
- R10: Reset gives idle: `bypass_gate` = 1 and all other outputs 0. The block leaves idle for filter mode only on a good grid sample with `bypass_fb` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grid_rms_err | input | ERR_W | Magnitude of grid RMS error, unsigned |
| grid_rms_ref | input | ERR_W | Nominal grid RMS reference, unsigned |
| grid_present | input | 1 | 1 when grid voltage is present |
| bypass_fb | input | 1 | Switch feedback, 1 = closed, 0 = open |
| sync_match | input | 1 | Output matches grid in phase and amplitude |
| cycle_tick | input | 1 | One-clock pulse per grid cycle |
| dc_link | input | DC_W | DC-link voltage sample, volts, unsigned |
| bypass_gate | output | 1 | Bypass switch gate, 1 = close |
| mode_backup | output | 1 | 1 = islanded backup, 0 = grid-tied |
| ref_freerun | output | 1 | 1 = reference from free-running clock |
| amp_reduced | output | 1 | 1 = reduced output amplitude class |
| iref_ramp_en | output | 1 | Grid-current reference ramp enable |
| inv_enable | output | 1 | Inverter switching enable |
| fb_fault | output | 1 | Latched switch-feedback timeout |

## Verification
Some rules are checked by the in-RTL properties on every cycle. A bad sample in filter mode must open the gate at the next edge. Islanded and filter modes may begin only after the matching switch feedback. A fault keeps the inverter off and the switch open, and it never clears. The free-running select appears only while islanded without a grid. A tick without a match must zero the match count. Other behaviour needs the bench's scenarios to show it. These include the exact threshold edges of the 15% limit at several reference levels, and the count of five ticks broken by a mismatch or by a fresh sag. They also include the DC-link thresholds, the timeout length and the return from the stopped state.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_FILTER   = 3'd1,
      ST_OPENING  = 3'd2,
      ST_BACKUP   = 3'd3,
      ST_CLOSING  = 3'd4,
      ST_SHUTDOWN = 3'd5,
      ST_FAULT    = 3'd6
   } sup_state_e;
endpackage

// File: rtl/mxs_sag_detect.sv
module mxs_sag_detect #(
   parameter int ERR_W     = 12,
   parameter int LIM_MUL   = 154,
   parameter int LIM_SHIFT = 10
) (
   input  logic [ERR_W-1:0] rms_err,
   input  logic [ERR_W-1:0] rms_ref,
   input  logic             grid_present,
   output logic             grid_bad,
   output logic             outage
);
   localparam int MUL_W  = $clog2(LIM_MUL + 1);
   localparam int PROD_W = ERR_W + MUL_W;

   if (LIM_MUL < 1) begin : g_bad_mul
      $error("LIM_MUL must be positive");
   end
   if (LIM_MUL >= (1 << LIM_SHIFT)) begin : g_bad_ratio
      $error("limit ratio must stay below one");
   end
   if (LIM_SHIFT >= PROD_W) begin : g_bad_shift
      $error("LIM_SHIFT too large for product width");
   end

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] limit;

   always_comb begin
      prod     = PROD_W'(rms_ref) * PROD_W'(LIM_MUL);
      limit    = prod >> LIM_SHIFT;
      outage   = !grid_present;
      grid_bad = outage || (PROD_W'(rms_err) > limit);
   end
endmodule

// File: rtl/mxs_match_count.sv
module mxs_match_count #(
   parameter int N_MATCH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cycle_tick,
   input  logic sync_match,
   output logic done
);
   localparam int CW = $clog2(N_MATCH + 1);

   if (N_MATCH < 1) begin : g_bad_n
      $error("N_MATCH must be at least one");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         cnt <= '0;
      end else if (cycle_tick) begin
         if (!sync_match)
            cnt <= '0;
         else if (cnt != CW'(N_MATCH))
            cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == CW'(N_MATCH));

   // R8: a tick without a match zeroes the run
   p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cycle_tick && !sync_match) |=> (cnt == '0));
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(N_MATCH));
endmodule

// File: rtl/mxs_fb_watchdog.sv
module mxs_fb_watchdog #(
   parameter int FB_TMO = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic restart,
   input  logic confirmed,
   output logic expired
);
   localparam int CW = $clog2(FB_TMO + 1);

   if (FB_TMO < 2) begin : g_bad_tmo
      $error("FB_TMO must be at least two");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !waiting || restart || confirmed)
         cnt <= '0;
      else if (cnt != CW'(FB_TMO - 1))
         cnt <= cnt + 1'b1;
   end

   assign expired = waiting && !confirmed && (cnt == CW'(FB_TMO - 1));

   p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !waiting |=> (cnt == '0));
endmodule

// File: rtl/mode_xfer_sup.sv
module mode_xfer_sup #(
   parameter int ERR_W     = 12,
   parameter int DC_W      = 10,
   parameter int LIM_MUL   = 154,
   parameter int LIM_SHIFT = 10,
   parameter int N_MATCH   = 5,
   parameter int FB_TMO    = 1000,
   parameter int DC_LOW    = 320,
   parameter int DC_CUT    = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] grid_rms_err,
   input  logic [ERR_W-1:0] grid_rms_ref,
   input  logic             grid_present,
   input  logic             bypass_fb,
   input  logic             sync_match,
   input  logic             cycle_tick,
   input  logic [DC_W-1:0]  dc_link,
   output logic             bypass_gate,
   output logic             mode_backup,
   output logic             ref_freerun,
   output logic             amp_reduced,
   output logic             iref_ramp_en,
   output logic             inv_enable,
   output logic             fb_fault
);
   import mxs_pkg::*;

   if (DC_CUT >= DC_LOW) begin : g_bad_dc
      $error("DC_CUT must lie below DC_LOW");
   end
   if (DC_LOW >= (1 << DC_W)) begin : g_bad_dcw
      $error("DC_LOW does not fit DC_W");
   end

   sup_state_e state, state_nxt;
   logic grid_bad, outage, match_done, fb_expired;
   logic waiting, confirmed, dc_low, dc_cut, islanded;

   mxs_sag_detect #(.ERR_W(ERR_W), .LIM_MUL(LIM_MUL), .LIM_SHIFT(LIM_SHIFT)) u_sag (
      .rms_err(grid_rms_err), .rms_ref(grid_rms_ref), .grid_present(grid_present),
      .grid_bad(grid_bad), .outage(outage));

   mxs_match_count #(.N_MATCH(N_MATCH)) u_match (
      .clk(clk), .rst_n(rst_n), .enable((state == ST_BACKUP) && !grid_bad),
      .cycle_tick(cycle_tick), .sync_match(sync_match), .done(match_done));

   assign waiting   = (state == ST_OPENING) || (state == ST_CLOSING);
   assign confirmed = (state == ST_OPENING) ? !bypass_fb : bypass_fb;

   mxs_fb_watchdog #(.FB_TMO(FB_TMO)) u_wdog (
      .clk(clk), .rst_n(rst_n), .waiting(waiting), .restart(state_nxt != state),
      .confirmed(confirmed), .expired(fb_expired));

   assign dc_low = dc_link < DC_W'(DC_LOW);
   assign dc_cut = dc_link < DC_W'(DC_CUT);

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:     if (!grid_bad && bypass_fb) state_nxt = ST_FILTER;
         ST_FILTER:   if (grid_bad) state_nxt = ST_OPENING;
         ST_OPENING: begin
            if (!bypass_fb)      state_nxt = ST_BACKUP;
            else if (fb_expired) state_nxt = ST_FAULT;
         end
         ST_BACKUP: begin
            if (dc_cut)          state_nxt = ST_SHUTDOWN;
            else if (match_done) state_nxt = ST_CLOSING;
         end
         ST_CLOSING: begin
            if (grid_bad)        state_nxt = ST_OPENING;
            else if (bypass_fb)  state_nxt = ST_FILTER;
            else if (fb_expired) state_nxt = ST_FAULT;
         end
         ST_SHUTDOWN: if (!grid_bad) state_nxt = ST_IDLE;
         ST_FAULT:    state_nxt = ST_FAULT;
         default:     state_nxt = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nxt;
   end

   assign islanded     = (state == ST_BACKUP) || (state == ST_CLOSING);
   assign bypass_gate  = (state == ST_IDLE) || (state == ST_FILTER) || (state == ST_CLOSING);
   assign inv_enable   = (state == ST_FILTER) || islanded;
   assign mode_backup  = islanded || (state == ST_SHUTDOWN);
   assign iref_ramp_en = (state == ST_FILTER);
   assign ref_freerun  = islanded && outage;
   assign amp_reduced  = islanded && dc_low;
   assign fb_fault     = (state == ST_FAULT);

   // R2
   p_gate_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILTER && grid_bad) |=> !bypass_gate);
   // R3
   p_backup_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_backup) |-> $past(!bypass_fb));
   // R4
   p_freerun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_freerun |-> (mode_backup && !grid_present));
   // R5
   p_close_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bypass_gate) && mode_backup) |-> $past(match_done));
   // R6
   p_filter_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iref_ramp_en) |-> $past(bypass_fb));
   // R7
   p_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BACKUP && dc_cut) |=> !inv_enable);
   // R9
   p_fault_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fb_fault |=> fb_fault);
   p_fault_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fb_fault |-> (!inv_enable && !bypass_gate));
endmodule

// File: tb/mode_xfer_sup_tb_top.sv
module mode_xfer_sup_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TMO = 8;
   localparam int VEC_N = 8;
   // {reference, error, grid_present, expect_open}
   localparam int VEC [VEC_N][4] = '{
      '{1000, 150, 1, 0}, '{1000, 151, 1, 1},
      '{2000, 300, 1, 0}, '{2000, 301, 1, 1},
      '{4095, 615, 1, 0}, '{4095, 616, 1, 1},
      '{1000,   0, 0, 1}, '{   0,   1, 1, 1}};

   logic clk = 0, rst_n = 0;
   logic [11:0] err = 0, ref_v = 1000;
   logic present = 0, fb = 1, match = 0, tick = 0;
   logic [9:0] dc = 442;
   logic gate, mode_b, freerun, amp_red, ramp, inv, fault;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mode_xfer_sup #(.FB_TMO(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .grid_rms_err(err), .grid_rms_ref(ref_v),
      .grid_present(present), .bypass_fb(fb), .sync_match(match), .cycle_tick(tick),
      .dc_link(dc), .bypass_gate(gate), .mode_backup(mode_b), .ref_freerun(freerun),
      .amp_reduced(amp_red), .iref_ramp_en(ramp), .inv_enable(inv), .fb_fault(fault));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_tick(input logic m);
      match = m; tick = 1; step(); tick = 0; step();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // bad sample from filter mode, leaves the block in OPENING
   task automatic trip();
      err = 12'd999; step(); err = 0;
   endtask

   task automatic recover();
      fb = 0; step();
      chk("R3 mode_backup", mode_b, 1); chk("R3 inv_enable", inv, 1);
      repeat (4) pulse_tick(1);
      chk("R5 gate after 4 ticks", gate, 0);
      pulse_tick(1);
      chk("R5 gate after 5 ticks", gate, 1);
      fb = 1; step();
      chk("R6 ramp", ramp, 1); chk("R6 mode_backup", mode_b, 0); chk("R6 inv", inv, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      step(); step();
      chk("R10 reset gate", gate, 1); chk("R10 reset inv", inv, 0);
      chk("R10 reset mode", mode_b, 0); chk("R10 reset ramp", ramp, 0);
      chk("R10 reset fault", fault, 0); chk("R10 reset freerun", freerun, 0);
      rst_n = 1;
      repeat (3) step();
      chk("R10 idle without grid", ramp, 0); chk("R10 idle inv", inv, 0);
      present = 1; step();
      chk("R10 filter on good grid", ramp, 1); chk("R6 filter inv", inv, 1);

      // R1 threshold table
      for (int i = 0; i < VEC_N; i++) begin
         ref_v = 12'(VEC[i][0]); err = 12'(VEC[i][1]); present = VEC[i][2][0];
         step();
         ref_v = 1000; err = 0; present = 1;
         chk($sformatf("R1 vector %0d gate", i), gate, VEC[i][3] == 0 ? 1 : 0);
         if (VEC[i][3] != 0) begin
            chk("R2 inv off at open", inv, 0); chk("R2 ramp off", ramp, 0);
            recover();
         end
      end

      // R3: switch reports closed, block must wait
      trip();
      repeat (3) step();
      chk("R3 wait mode", mode_b, 0); chk("R3 wait gate", gate, 0);
      fb = 0; step();
      chk("R3 entry", mode_b, 1);
      // R4
      present = 0; step();
      chk("R4 freerun outage", freerun, 1);
      present = 1; step();
      chk("R4 locked with grid", freerun, 0);
      // R8 mismatch breaks run
      repeat (3) pulse_tick(1);
      pulse_tick(0);
      repeat (4) pulse_tick(1);
      chk("R8 gate after mismatch", gate, 0);
      // R8 sag breaks run
      err = 12'd999; step(); err = 0;
      repeat (4) pulse_tick(1);
      chk("R8 gate after sag", gate, 0);
      pulse_tick(1);
      chk("R8 gate after full run", gate, 1);
      fb = 1; step();
      chk("R6 back to filter", ramp, 1);

      // R7
      trip(); fb = 0; step();
      dc = 319; step();
      chk("R7 reduced below 320", amp_red, 1);
      dc = 320; step();
      chk("R7 full at 320", amp_red, 0);
      present = 0; dc = 200; step();
      chk("R7 still supplying", inv, 1);
      dc = 159; step();
      chk("R7 shutdown inv", inv, 0); chk("R7 shutdown gate", gate, 0);
      present = 1; dc = 442; step();
      chk("R7 idle after return", gate, 1); chk("R7 idle inv", inv, 0);
      fb = 1; step();
      chk("R7 filter after idle", ramp, 1);

      // R9 timeout
      trip();
      repeat (TMO + 4) step();
      chk("R9 fault raised", fault, 1); chk("R9 inv off", inv, 0); chk("R9 gate open", gate, 0);
      fb = 0; repeat (3) step();
      chk("R9 fault held", fault, 1);
      rst_n = 0; step(); rst_n = 1; fb = 1;
      chk("R9 cleared by reset", fault, 0);

      finished = 1;
      summary();
      $finish;
   end
endmodule